// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block produces what a host sees on the data bus of a two-bank parallel flash while an internal program or erase runs. It does not store the array or decode the command sequences. Both are handled elsewhere. The neighbouring logic reports each finished command as a one-cycle event. These events are start program, start erase with a sector mask, suspend and resume. The array side reports the end of a real operation with a completion pulse.

For every read, the block decides what the read returns. It is either the array byte supplied by the array side, or a status byte. The status byte carries two toggle bits. The operation bit flips on every status read while the bank is busy. The sector bit flips only on reads of sectors that are marked for erase.

When a program targets a protected sector, the block shows a timed false busy window instead of running the operation. An erase whose selected sectors are all protected gets the same treatment. Ready/busy leaves the block as an open-drain pull-down enable, so that several devices can share one pulled-up line.

Reads form a plain request/response stream with no back-pressure. A request on `rd_en` always produces `rd_valid`, with its byte, exactly one cycle later. A response cannot be stalled or dropped, so the reader must accept every response. Commands are accepted in the cycle they are pulsed, and a read in the same cycle is answered from the old state. Status is therefore valid from the cycle after the command.

Top module: `flash_opstat`

## Requirements
- R1: After reset the block is idle. `rb_pulldown` is 0, and every read returns `array_rdata` of its request cycle on `rd_data`, with `rd_valid` high one cycle after `rd_en`.
- R2: After a program start on an unprotected sector, status reads to the operating bank return bit 6 as 0, 1, 0, ... (one flip per read). An `op_done` pulse ends the program, and later reads return array data.
- R3: While any operation or suspend is in force, reads to the other bank return array data and do not advance either toggle bit.
- R4: After an erase start, the erase set is the erase mask with the protected sectors removed. Bit 2 starts at 0 and flips on each read of a sector in that set in the operating bank. Reads of other sectors return the bit unchanged. Bit 6 flips on every read of the bank.
- R5: A suspend during a real erase enters erase-suspend, and `rb_pulldown` is released. Reads of erase-set sectors return status with bit 6 held and bit 2 still flipping. Reads of other sectors in the bank return array data. A resume returns to erasing.
- R6: A program start during erase-suspend drives `rb_pulldown` and restarts bit 6 at 0, flipping per read of the bank. Its `op_done` returns the bank to erase-suspend.
- R7: A program start on a protected sector keeps the block busy for exactly PROT_PGM_CYC cycles and then returns to idle. `op_done` is ignored during this window.
- R8: An erase start whose erase set is empty (all selected sectors protected, or none selected) keeps the block busy for exactly PROT_ERS_CYC cycles and then returns to idle. Suspend is ignored during this window.
- R9: `rb_pulldown` is 1 exactly while programming, erasing, or programming inside erase-suspend.
- R10: A status byte carries `timeout_flag` of the request cycle in bit 5, and bits 7, 4, 3, 1 and 0 are 0.
- R11: A command that does not fit the current state is ignored. This covers any start while a program or erase runs, a suspend when not erasing, and a resume when not suspended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read request, one per cycle |
| rd_bank | input | BANK_W | Decoded bank of the read address |
| rd_sector | input | SECT_W | Decoded sector of the read address |
| array_rdata | input | 8 | Array byte for the read address |
| timeout_flag | input | 1 | Operation time-limit flag, reported in bit 5 |
| rd_valid | output | 1 | Response valid, one cycle after rd_en |
| rd_data | output | 8 | Response byte: array data or status |
| cmd_pgm | input | 1 | Program command accepted (pulse) |
| cmd_ers | input | 1 | Erase command accepted (pulse) |
| cmd_susp | input | 1 | Suspend command (pulse) |
| cmd_resume | input | 1 | Resume command (pulse) |
| cmd_bank | input | BANK_W | Bank targeted by a program or erase start |
| cmd_sector | input | SECT_W | Sector targeted by a program |
| ers_mask | input | NSECT | Sectors selected for erase |
| prot_mask | input | NSECT | Protected sectors |
| op_done | input | 1 | Real internal operation finished (pulse) |
| rb_pulldown | output | 1 | Open-drain enable: 1 pulls the shared ready/busy line low |

## Verification
The response function is driven with random reads that spread over both banks, over erase-set and other sectors, with random array bytes and timeout flags. This is done in three phases: erasing, suspended, and programming inside the suspend. Each random read is compared with a bench model. The phases separate which of the two toggle bits may advance, and whether the byte is status or array data. Directed sequences cover the following cases:
- a plain program, which shows the 0,1,0 order and the return to array data;
- reads to the idle bank;
- commands that must be ignored;
- both false busy windows, counted cycle by cycle, with a completion pulse or a suspend placed inside each window to prove it has no effect.

// File: rtl/flash_opstat_pkg.sv
package flash_opstat_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PGM,
    PH_ERS,
    PH_SUSP,
    PH_PSUSP
  } phase_t;

  localparam int unsigned BIT_OPTOG  = 6;
  localparam int unsigned BIT_TMO    = 5;
  localparam int unsigned BIT_SECTOG = 2;

  function automatic logic phase_running(phase_t p);
    return (p == PH_PGM) || (p == PH_ERS) || (p == PH_PSUSP);
  endfunction

  function automatic logic phase_erase_marked(phase_t p);
    return (p == PH_ERS) || (p == PH_SUSP) || (p == PH_PSUSP);
  endfunction

endpackage

// File: rtl/flash_opstat_ctrl.sv
module flash_opstat_ctrl
  import flash_opstat_pkg::*;
#(
  parameter int unsigned NSECT        = 16,
  parameter int unsigned NBANK        = 2,
  parameter int unsigned PROT_PGM_CYC = 100,
  parameter int unsigned PROT_ERS_CYC = 10000,
  localparam int unsigned SECT_W = $clog2(NSECT),
  localparam int unsigned BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_pgm,
  input  logic              cmd_ers,
  input  logic              cmd_susp,
  input  logic              cmd_resume,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [SECT_W-1:0] cmd_sector,
  input  logic [NSECT-1:0]  ers_mask,
  input  logic [NSECT-1:0]  prot_mask,
  input  logic              op_done,
  output phase_t            phase,
  output logic [BANK_W-1:0] op_bank,
  output logic [NSECT-1:0]  ers_set,
  output logic              start_pgm,
  output logic              start_ers,
  output logic              busy
);

  localparam int unsigned TMAX = (PROT_PGM_CYC > PROT_ERS_CYC) ? PROT_PGM_CYC : PROT_ERS_CYC;
  localparam int unsigned TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] PGM_LOAD = TW'(PROT_PGM_CYC - 1);
  localparam logic [TW-1:0] ERS_LOAD = TW'(PROT_ERS_CYC - 1);

  phase_t          state;
  logic            fake;
  logic [TW-1:0]   timer;
  logic [NSECT-1:0] new_set;
  logic            finish;

  assign new_set   = ers_mask & ~prot_mask;
  assign finish    = fake ? (timer == '0) : op_done;
  assign start_pgm = cmd_pgm && ((state == PH_IDLE) || (state == PH_SUSP));
  assign start_ers = cmd_ers && !cmd_pgm && (state == PH_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= PH_IDLE;
      fake    <= 1'b0;
      timer   <= '0;
      op_bank <= '0;
      ers_set <= '0;
    end else begin
      if (fake && (timer != '0)) timer <= timer - TW'(1);
      unique case (state)
        PH_IDLE: begin
          if (cmd_pgm) begin
            state   <= PH_PGM;
            op_bank <= cmd_bank;
            fake    <= prot_mask[cmd_sector];
            timer   <= PGM_LOAD;
          end else if (cmd_ers) begin
            state   <= PH_ERS;
            op_bank <= cmd_bank;
            ers_set <= new_set;
            fake    <= (new_set == '0);
            timer   <= ERS_LOAD;
          end
        end
        PH_PGM: begin
          if (finish) begin
            state <= PH_IDLE;
            fake  <= 1'b0;
          end
        end
        PH_ERS: begin
          if (finish) begin
            state <= PH_IDLE;
            fake  <= 1'b0;
          end else if (cmd_susp && !fake) begin
            state <= PH_SUSP;
          end
        end
        PH_SUSP: begin
          if (cmd_pgm) begin
            state <= PH_PSUSP;
            fake  <= prot_mask[cmd_sector];
            timer <= PGM_LOAD;
          end else if (cmd_resume) begin
            state <= PH_ERS;
          end
        end
        PH_PSUSP: begin
          if (finish) begin
            state <= PH_SUSP;
            fake  <= 1'b0;
          end
        end
        default: state <= PH_IDLE;
      endcase
    end
  end

  assign phase = state;
  assign busy  = phase_running(state);

  // R8: a false erase window never enters suspend
  p_fake_no_susp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_ERS && fake) |=> (state != PH_SUSP));

  // R11: suspend only leaves on program start or resume
  p_susp_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_SUSP && !cmd_pgm && !cmd_resume) |=> (state == PH_SUSP));

  // R7: a false program window ignores op_done while its timer runs
  p_fake_pgm_ignores_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_PGM && fake && timer != '0) |=> (state == PH_PGM));

endmodule

// File: rtl/flash_opstat_toggle.sv
module flash_opstat_toggle
  import flash_opstat_pkg::*;
#(
  parameter int unsigned NSECT = 16,
  parameter int unsigned NBANK = 2,
  localparam int unsigned SECT_W = $clog2(NSECT),
  localparam int unsigned BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_t            phase,
  input  logic [BANK_W-1:0] op_bank,
  input  logic [NSECT-1:0]  ers_set,
  input  logic              start_pgm,
  input  logic              start_ers,
  input  logic              rd_en,
  input  logic [BANK_W-1:0] rd_bank,
  input  logic [SECT_W-1:0] rd_sector,
  output logic              op_tog,
  output logic              sec_tog,
  output logic              status_sel
);

  logic in_bank;
  logic in_set;
  logic flip_op;
  logic flip_sec;

  assign in_bank = (rd_bank == op_bank);
  assign in_set  = ers_set[rd_sector];

  always_comb begin
    unique case (phase)
      PH_PGM, PH_ERS, PH_PSUSP: status_sel = in_bank;
      PH_SUSP:                  status_sel = in_bank && in_set;
      default:                  status_sel = 1'b0;
    endcase
  end

  assign flip_op  = rd_en && in_bank && phase_running(phase);
  assign flip_sec = rd_en && in_bank && in_set && phase_erase_marked(phase);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_tog  <= 1'b0;
      sec_tog <= 1'b0;
    end else begin
      if (start_pgm || start_ers) op_tog <= 1'b0;
      else if (flip_op)           op_tog <= ~op_tog;
      if (start_ers)              sec_tog <= 1'b0;
      else if (flip_sec)          sec_tog <= ~sec_tog;
    end
  end

  // R5: the operation bit holds through erase-suspend
  p_optog_hold_susp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SUSP && !start_pgm) |=> $stable(op_tog));

  // R3: reads of the other bank leave the sector bit alone
  p_sectog_other_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_bank != op_bank && !start_ers) |=> $stable(sec_tog));

  // R4: the sector bit never moves during a plain program
  p_sectog_pgm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PGM && !start_ers) |=> $stable(sec_tog));

endmodule

// File: rtl/flash_opstat_resp.sv
module flash_opstat_resp
  import flash_opstat_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_en,
  input  logic       status_sel,
  input  logic       op_tog,
  input  logic       sec_tog,
  input  logic       timeout_flag,
  input  logic [7:0] array_rdata,
  output logic       rd_valid,
  output logic [7:0] rd_data
);

  logic [7:0] status_byte;

  always_comb begin
    status_byte             = 8'h00;
    status_byte[BIT_OPTOG]  = op_tog;
    status_byte[BIT_TMO]    = timeout_flag;
    status_byte[BIT_SECTOG] = sec_tog;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= 8'h00;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= status_sel ? status_byte : array_rdata;
    end
  end

  // R1: every request is answered on the next cycle
  p_resp_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  // R3: array reads pass the array byte of the request cycle
  p_array_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !status_sel) |=> (rd_data == $past(array_rdata)));

endmodule

// File: rtl/flash_opstat.sv
module flash_opstat
  import flash_opstat_pkg::*;
#(
  parameter int unsigned NSECT        = 16,
  parameter int unsigned NBANK        = 2,
  parameter int unsigned PROT_PGM_CYC = 100,
  parameter int unsigned PROT_ERS_CYC = 10000,
  localparam int unsigned SECT_W = $clog2(NSECT),
  localparam int unsigned BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [BANK_W-1:0] rd_bank,
  input  logic [SECT_W-1:0] rd_sector,
  input  logic [7:0]        array_rdata,
  input  logic              timeout_flag,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  input  logic              cmd_pgm,
  input  logic              cmd_ers,
  input  logic              cmd_susp,
  input  logic              cmd_resume,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [SECT_W-1:0] cmd_sector,
  input  logic [NSECT-1:0]  ers_mask,
  input  logic [NSECT-1:0]  prot_mask,
  input  logic              op_done,
  output logic              rb_pulldown
);

  phase_t            phase;
  logic [BANK_W-1:0] op_bank;
  logic [NSECT-1:0]  ers_set;
  logic              start_pgm;
  logic              start_ers;
  logic              busy;
  logic              op_tog;
  logic              sec_tog;
  logic              status_sel;

  flash_opstat_ctrl #(
    .NSECT(NSECT), .NBANK(NBANK),
    .PROT_PGM_CYC(PROT_PGM_CYC), .PROT_ERS_CYC(PROT_ERS_CYC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_pgm(cmd_pgm), .cmd_ers(cmd_ers), .cmd_susp(cmd_susp), .cmd_resume(cmd_resume),
    .cmd_bank(cmd_bank), .cmd_sector(cmd_sector),
    .ers_mask(ers_mask), .prot_mask(prot_mask), .op_done(op_done),
    .phase(phase), .op_bank(op_bank), .ers_set(ers_set),
    .start_pgm(start_pgm), .start_ers(start_ers), .busy(busy)
  );

  flash_opstat_toggle #(.NSECT(NSECT), .NBANK(NBANK)) u_tog (
    .clk(clk), .rst_n(rst_n),
    .phase(phase), .op_bank(op_bank), .ers_set(ers_set),
    .start_pgm(start_pgm), .start_ers(start_ers),
    .rd_en(rd_en), .rd_bank(rd_bank), .rd_sector(rd_sector),
    .op_tog(op_tog), .sec_tog(sec_tog), .status_sel(status_sel)
  );

  flash_opstat_resp u_resp (
    .clk(clk), .rst_n(rst_n),
    .rd_en(rd_en), .status_sel(status_sel),
    .op_tog(op_tog), .sec_tog(sec_tog), .timeout_flag(timeout_flag),
    .array_rdata(array_rdata),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assign rb_pulldown = busy;

  // R1: idle never pulls the shared line low
  p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> !rb_pulldown);

  // R9: a program start is busy from the next cycle
  p_pgm_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_pgm |=> rb_pulldown);

endmodule

// File: tb/flash_opstat_bench.sv
`timescale 1ns/1ps
module flash_opstat_bench;

  localparam int NSECT = 16;
  localparam int PGM_N = 8;
  localparam int ERS_N = 20;
  localparam logic [15:0] PROT = 16'h00F0;

  localparam int MI = 0, MP = 1, ME = 2, MS = 3, MQ = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_en = 1'b0;
  logic [0:0] rd_bank = '0;
  logic [3:0] rd_sector = '0;
  logic [7:0] array_rdata = '0;
  logic timeout_flag = 1'b0;
  logic rd_valid;
  logic [7:0] rd_data;
  logic cmd_pgm = 1'b0, cmd_ers = 1'b0, cmd_susp = 1'b0, cmd_resume = 1'b0;
  logic [0:0] cmd_bank = '0;
  logic [3:0] cmd_sector = '0;
  logic [15:0] ers_mask = '0;
  logic [15:0] prot_mask = PROT;
  logic op_done = 1'b0;
  logic rb_pulldown;
  wire  rb_line = ~rb_pulldown;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int m_ph = MI;
  int m_bank = 0;
  logic [15:0] m_set = '0;
  bit m_t6 = 0, m_t2 = 0;

  always #5 clk = ~clk;

  flash_opstat #(.NSECT(NSECT), .NBANK(2), .PROT_PGM_CYC(PGM_N), .PROT_ERS_CYC(ERS_N)) u_flash_opstat (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_bank(rd_bank), .rd_sector(rd_sector),
    .array_rdata(array_rdata), .timeout_flag(timeout_flag),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .cmd_pgm(cmd_pgm), .cmd_ers(cmd_ers), .cmd_susp(cmd_susp), .cmd_resume(cmd_resume),
    .cmd_bank(cmd_bank), .cmd_sector(cmd_sector), .ers_mask(ers_mask), .prot_mask(prot_mask),
    .op_done(op_done), .rb_pulldown(rb_pulldown)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(int b, int s, logic [7:0] arr, bit to);
    bit inb = (b == m_bank);
    bit st = ((m_ph == MP || m_ph == ME || m_ph == MQ) && inb) ||
             (m_ph == MS && inb && m_set[s]);
    if (!st) return arr;
    return {1'b0, m_t6, to, 2'b00, m_t2, 2'b00};
  endfunction

  function automatic bit exp_busy();
    return (m_ph == MP || m_ph == ME || m_ph == MQ);
  endfunction

  task automatic do_read(input string req, input int b, input int s, input logic [7:0] arr, input bit to);
    logic [7:0] e;
    bit inb;
    e = exp_byte(b, s, arr, to);
    rd_en = 1'b1; rd_bank = b[0:0]; rd_sector = s[3:0]; array_rdata = arr; timeout_flag = to;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    check({req, " valid"}, int'(rd_valid), 1);
    check({req, " data"}, int'(rd_data), int'(e));
    inb = (b == m_bank);
    if (inb && (m_ph == MP || m_ph == ME || m_ph == MQ)) m_t6 = ~m_t6;
    if (inb && m_set[s] && (m_ph == ME || m_ph == MS || m_ph == MQ)) m_t2 = ~m_t2;
  endtask

  task automatic pulse(input int which);
    case (which)
      0: cmd_pgm = 1'b1;
      1: cmd_ers = 1'b1;
      2: cmd_susp = 1'b1;
      3: cmd_resume = 1'b1;
      default: op_done = 1'b1;
    endcase
    @(negedge clk);
    cmd_pgm = 1'b0; cmd_ers = 1'b0; cmd_susp = 1'b0; cmd_resume = 1'b0; op_done = 1'b0;
  endtask

  task automatic rand_reads(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      int b;
      int s;
      b = ($urandom % 4 == 0) ? (1 - m_bank) : m_bank;
      s = $urandom % NSECT;
      do_read(req, b, s, 8'($urandom), bit'($urandom % 2));
    end
  endtask

  task automatic check_busy(input string req);
    check(req, int'(rb_line), exp_busy() ? 0 : 1);
  endtask

  initial begin
    #(2_000_000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 line released", int'(rb_line), 1);
    do_read("R1 idle read", 0, 3, 8'hA5, 1'b1);
    do_read("R1 idle read b1", 1, 9, 8'h3C, 1'b0);

    // R11 resume and suspend while idle ignored
    pulse(3); pulse(2);
    check("R11 idle stays", int'(rb_line), 1);

    // R2 program on unprotected sector 2, bank 0
    cmd_bank = 1'b0; cmd_sector = 4'd2;
    pulse(0); m_ph = MP; m_bank = 0; m_t6 = 0;
    check_busy("R9 program busy");
    do_read("R2 first", 0, 2, 8'h11, 1'b0);
    do_read("R2 second", 0, 7, 8'h22, 1'b0);
    do_read("R2 third", 0, 0, 8'h33, 1'b0);
    do_read("R3 other bank", 1, 2, 8'h44, 1'b0);
    do_read("R2 fourth", 0, 2, 8'h55, 1'b0);
    do_read("R10 timeout bit", 0, 1, 8'hFF, 1'b1);
    // R11 erase, program, suspend during program ignored
    ers_mask = 16'hFFFF;
    pulse(1); pulse(0); pulse(2);
    check_busy("R11 still programming");
    do_read("R11 program unchanged", 0, 4, 8'h66, 1'b0);
    pulse(4); m_ph = MI;
    check_busy("R2 done released");
    do_read("R2 array after done", 0, 2, 8'h77, 1'b0);

    // R4 erase with partly protected mask on bank 1
    ers_mask = 16'h0F3C; cmd_bank = 1'b1;
    pulse(1); m_ph = ME; m_bank = 1; m_set = 16'h0F3C & ~PROT; m_t6 = 0; m_t2 = 0;
    check_busy("R9 erase busy");
    do_read("R4 set sector", 1, 2, 8'h01, 1'b0);
    do_read("R4 protected sector", 1, 4, 8'h02, 1'b0);
    do_read("R4 unselected sector", 1, 0, 8'h03, 1'b0);
    do_read("R4 set sector again", 1, 11, 8'h04, 1'b0);
    rand_reads("R4 random erase", 40);

    // R5 suspend
    pulse(2); m_ph = MS;
    check_busy("R5 suspend released");
    do_read("R5 set sector", 1, 3, 8'h05, 1'b0);
    do_read("R5 set sector 2", 1, 8, 8'h06, 1'b1);
    do_read("R5 unselected array", 1, 15, 8'h07, 1'b0);
    rand_reads("R5 random suspend", 40);

    // R6 program in suspend
    cmd_sector = 4'd14;
    pulse(0); m_ph = MQ; m_t6 = 0;
    check_busy("R6 program busy");
    do_read("R6 first", 1, 14, 8'h08, 1'b0);
    rand_reads("R6 random", 40);
    pulse(4); m_ph = MS;
    check_busy("R6 back to suspend");
    do_read("R6 suspend again", 1, 2, 8'h09, 1'b0);

    // R5 resume
    pulse(3); m_ph = ME;
    check_busy("R5 resume busy");
    rand_reads("R5 random resumed", 20);
    pulse(4); m_ph = MI;
    check_busy("R4 erase done");
    do_read("R4 array after erase", 1, 2, 8'h0A, 1'b0);

    // R7 protected program window, op_done inside ignored
    begin
      int n;
      cmd_bank = 1'b0; cmd_sector = 4'd5;
      pulse(0);
      n = 0;
      while (rb_pulldown && n < 1000) begin
        op_done = (n == 2);
        n++;
        @(negedge clk);
      end
      op_done = 1'b0;
      check("R7 window length", n, PGM_N);
      do_read("R7 array after window", 0, 5, 8'h0B, 1'b0);
    end

    // R8 all-protected erase window, suspend inside ignored
    begin
      int n;
      ers_mask = 16'h0030; cmd_bank = 1'b0;
      pulse(1);
      n = 0;
      while (rb_pulldown && n < 1000) begin
        cmd_susp = (n == 5);
        n++;
        @(negedge clk);
      end
      cmd_susp = 1'b0;
      check("R8 window length", n, ERS_N);
      do_read("R8 array after window", 0, 4, 8'h0C, 1'b0);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule